// File: doc/BRIEF.md
# PC Card I/O Cycle Controller

This block turns single-beat internal requests into bus cycles for a PC Card style card slot. A request gives an address, write data, a size (byte or 16-bit word), a direction and one of two address spaces. Each space has its own interface mode (I/O card or memory card), its own data width (8 or 16 bits) and its own setup delay. The delay is the time from the card enables to the read or write strobe, counted in half clock periods. The block drives the two active-low card enables, the I/O or memory read and write strobes, the card address and the write data. It returns the read data and a one-clock completion pulse.

The block sizes the bus during the cycle itself. Take a word access to a 16-bit I/O space in little-endian operation. The card raises `io_narrow` to report that it is only 8 bits wide. The block samples that input on falling clock edges and releases the upper-byte enable part way through the cycle. It transfers only the low byte, then runs a second byte cycle on its own for the high byte, and hands back one reassembled 16-bit result.

The controller has six states. `ST_IDLE` waits for a request. `ST_SETUP` holds the enables while the setup delay runs. `ST_STROBE` holds the strobe. `ST_HOLD` keeps the enables for one clock after the strobe ends. `ST_NEXT` is one clock with the enables off, between the two halves of a split access. `ST_DONE` gives the completion pulse.

The transitions are:
- `ST_IDLE` goes to `ST_SETUP` on a request, or to `ST_STROBE` if the setup delay is zero.
- `ST_SETUP` goes to `ST_STROBE` when its count reaches its end.
- `ST_STROBE` goes to `ST_HOLD` after the strobe width.
- `ST_HOLD` goes to `ST_NEXT` when the first half of an access is narrowed, and to `ST_DONE` in every other case.
- `ST_NEXT` goes to `ST_SETUP`, or to `ST_STROBE` if the delay is zero.
- `ST_DONE` goes back to `ST_IDLE`.

Top module: `pcc_io_ctrl`

## Requirements
- R1: While `rst_n` is low, `ce1_n`, `ce2_n`, `iord_n`, `iowr_n`, `memrd_n` and `memwr_n` are all 1, and `card_doe` and `done` are 0.
- R2: A space whose mode field equals 2'b01 uses `iord_n` (read) or `iowr_n` (write). Any other mode value uses `memrd_n` or `memwr_n`. The unused strobe pair stays at 1, and at most one strobe is low at any time.
- R3: In every bus cycle, the strobe goes low d half clock periods after `ce1_n` goes low, where d is the 4-bit delay field of the addressed space (0 to 15).
- R4: The strobe stays low for 2 clocks, plus one extra half clock when d is odd. It returns high one full clock before `ce1_n` returns high.
- R5: A word access (`req_word`=1) to a 16-bit space (`cfg_wideN`=1) that is not narrowed runs as one cycle with `ce1_n` and `ce2_n` both low. It drives address bit 0 as 0, puts write data on all 16 lines, and returns `card_din[15:0]` as read data.
- R6: A narrowed access runs as two cycles without a second request. This happens when the space is in I/O mode, the space is 16 bits wide, the access is a word, `cfg_little`=1, and `io_narrow` is high. The first cycle uses address bit 0 = 0 and carries `wdata[7:0]` on `card_dout[7:0]`. The second uses address bit 0 = 1 and carries `wdata[15:8]` on `card_dout[7:0]`. Read data is returned as {second `card_din[7:0]`, first `card_din[7:0]`}.
- R7: In a 16-bit word cycle, `ce2_n` goes low together with `ce1_n`. In a narrowed cycle, `ce2_n` returns high at the second rising edge after `ce1_n` went low, which is 1.5 clocks after the first falling-edge sample of `io_narrow`. The second byte cycle of a split access keeps `ce2_n` high.
- R8: When `cfg_little`=0, or the space is in memory-card mode, `io_narrow` is ignored, and a word access to a 16-bit space completes as a single 16-bit cycle.
- R9: A byte access, or any access to an 8-bit space, runs as one cycle with `ce2_n` high and data on bits 7:0. It returns {8'h00, `card_din[7:0]`}. A word access to an 8-bit space drives address bit 0 as 0.
- R10: `done` is high for exactly one clock, in the clock that follows the last cycle's `ce1_n` release. `rd_data` is valid while `done` is high.
- R11: A `req_valid` that arrives while an access is in progress is ignored. It starts no further bus cycle and gives no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode0 | input | 2 | Space 0 interface mode (2'b01 = I/O card) |
| cfg_mode1 | input | 2 | Space 1 interface mode (2'b01 = I/O card) |
| cfg_wide0 | input | 1 | Space 0 bus width, 1 = 16 bits |
| cfg_wide1 | input | 1 | Space 1 bus width, 1 = 16 bits |
| cfg_dly0 | input | 4 | Space 0 enable-to-strobe delay in half clocks |
| cfg_dly1 | input | 4 | Space 1 enable-to-strobe delay in half clocks |
| cfg_little | input | 1 | 1 = little-endian operation |
| req_valid | input | 1 | Start an access (taken only when idle) |
| req_space | input | 1 | Selects space 0 or 1 |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| io_narrow | input | 1 | Card reports an 8-bit data path |
| card_din | input | 16 | Read data from the card |
| ce1_n | output | 1 | Low-byte card enable, active low |
| ce2_n | output | 1 | High-byte card enable, active low |
| iord_n | output | 1 | I/O read strobe, active low |
| iowr_n | output | 1 | I/O write strobe, active low |
| memrd_n | output | 1 | Memory read strobe, active low |
| memwr_n | output | 1 | Memory write strobe, active low |
| card_addr | output | 16 | Card address |
| card_dout | output | 16 | Write data to the card |
| card_doe | output | 1 | Write data drive enable |
| rd_data | output | 16 | Assembled read data |
| done | output | 1 | One-clock completion pulse |

## Verification
The assertions and the sizing decision assume that `io_narrow` is settled by the first falling-edge sample of a cycle and does not move until the cycle ends. They also assume that `card_din` follows the card address. The stimulus changes `io_narrow` and the space settings only while the block is idle, between accesses. The card model drives read data as a pure function of `card_addr`. Random accesses are mixed with directed sweeps of every delay value, narrowed accesses in both endian settings and both modes, and requests pulsed during a busy access.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_NEXT,
        ST_DONE
    } pcc_state_e;

    // mode field value that selects the I/O card interface
    localparam logic [1:0] MODE_IO = 2'b01;

    // clocks after enable assertion at which the high enable may drop
    localparam int unsigned CE2_SETTLE = 2;

endpackage

// File: rtl/pcc_cfg_sel.sv
module pcc_cfg_sel #(
    parameter int unsigned NSP   = 2,
    parameter int unsigned DLY_W = 4,
    localparam int unsigned SP_W = (NSP > 1) ? $clog2(NSP) : 1
) (
    input  logic [NSP-1:0][1:0]       mode,
    input  logic [NSP-1:0]            wide,
    input  logic [NSP-1:0][DLY_W-1:0] dly,
    input  logic [SP_W-1:0]           space,
    output logic                      sel_io,
    output logic                      sel_wide,
    output logic [DLY_W-1:0]          sel_dly
);
    import pcc_pkg::*;

    logic [NSP-1:0] is_io;

    // per-space decode of the interface mode
    for (genvar g = 0; g < NSP; g++) begin : g_space
        assign is_io[g] = (mode[g] == MODE_IO);
    end

    always_comb begin
        sel_io   = is_io[space];
        sel_wide = wide[space];
        sel_dly  = dly[space];
    end

endmodule

// File: rtl/pcc_negsamp.sv
module pcc_negsamp (
    input  logic clk,
    input  logic rst_n,
    input  logic early_set,
    input  logic samp_en,
    input  logic io_narrow,
    output logic early_q,
    output logic narrow_q
);
    // falling-edge registers give the half-clock resolution
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            early_q  <= 1'b0;
            narrow_q <= 1'b0;
        end else begin
            early_q <= early_set;
            if (samp_en) begin
                narrow_q <= io_narrow;
            end
        end
    end

endmodule

// File: rtl/pcc_seq.sv
module pcc_seq #(
    parameter int unsigned AW      = 16,
    parameter int unsigned DLY_W   = 4,
    parameter int unsigned STB_CYC = 2,
    localparam int unsigned STB_W  = $clog2(STB_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_word,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [15:0]      req_wdata,
    input  logic             sel_io,
    input  logic             sel_wide,
    input  logic             sel_little,
    input  logic [DLY_W-1:0] sel_dly,
    input  logic [15:0]      card_din,
    input  logic             early_q,
    input  logic             narrow_q,
    output logic             early_set,
    output logic             samp_en,
    output logic             ce1_n,
    output logic             ce2_n,
    output logic             iord_n,
    output logic             iowr_n,
    output logic             memrd_n,
    output logic             memwr_n,
    output logic [AW-1:0]    card_addr,
    output logic [15:0]      card_dout,
    output logic             card_doe,
    output logic [15:0]      rd_data,
    output logic             done
);
    import pcc_pkg::*;

    pcc_state_e        state, nxt;
    logic              part;
    logic [DLY_W-1:0]  cnt, lat_setup;
    logic              lat_odd;
    logic [STB_W-1:0]  scnt;
    logic [1:0]        age;
    logic [AW-1:0]     lat_addr;
    logic [15:0]       lat_wdata, rd_q;
    logic              lat_word, lat_write, lat_io, lat_w16, lat_dyn;
    logic              split_now, ce_on, stb_on, ce2_on;
    logic [DLY_W-1:0]  req_setup;

    // whole clocks of setup: ceil(d/2)
    function automatic logic [DLY_W-1:0] setup_of(input logic [DLY_W-1:0] d);
        return (d >> 1) + {{(DLY_W-1){1'b0}}, d[0]};
    endfunction

    assign req_setup = setup_of(sel_dly);
    assign split_now = !part && lat_dyn && narrow_q;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req_valid) nxt = (req_setup == '0) ? ST_STROBE : ST_SETUP;
            ST_SETUP:  if (cnt == DLY_W'(1)) nxt = ST_STROBE;
            ST_STROBE: if (scnt == '0) nxt = ST_HOLD;
            ST_HOLD:   nxt = split_now ? ST_NEXT : ST_DONE;
            ST_NEXT:   nxt = (lat_setup == '0) ? ST_STROBE : ST_SETUP;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            part      <= 1'b0;
            cnt       <= '0;
            lat_setup <= '0;
            lat_odd   <= 1'b0;
            scnt      <= '0;
            age       <= '0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_word  <= 1'b0;
            lat_write <= 1'b0;
            lat_io    <= 1'b0;
            lat_w16   <= 1'b0;
            lat_dyn   <= 1'b0;
            rd_q      <= '0;
        end else begin
            state <= nxt;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        part      <= 1'b0;
                        cnt       <= req_setup;
                        lat_setup <= req_setup;
                        lat_odd   <= sel_dly[0];
                        scnt      <= STB_W'(STB_CYC - 1);
                        age       <= '0;
                        lat_addr  <= req_addr;
                        lat_wdata <= req_wdata;
                        lat_word  <= req_word;
                        lat_write <= req_write;
                        lat_io    <= sel_io;
                        lat_w16   <= sel_wide && req_word;
                        lat_dyn   <= sel_io && sel_wide && sel_little && req_word;
                    end
                end
                ST_SETUP: begin
                    cnt <= cnt - DLY_W'(1);
                    if (age != 2'd3) age <= age + 2'd1;
                end
                ST_STROBE: begin
                    scnt <= scnt - STB_W'(1);
                    if (age != 2'd3) age <= age + 2'd1;
                    if (scnt == '0) begin
                        if (part)         rd_q[15:8] <= card_din[7:0];
                        else if (lat_w16) rd_q       <= card_din;
                        else              rd_q       <= {8'h00, card_din[7:0]};
                    end
                end
                ST_HOLD: begin
                    if (age != 2'd3) age <= age + 2'd1;
                end
                ST_NEXT: begin
                    part <= 1'b1;
                    cnt  <= lat_setup;
                    scnt <= STB_W'(STB_CYC - 1);
                    age  <= '0;
                end
                ST_DONE: begin
                    part <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // output decode
    always_comb begin
        ce_on  = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
        stb_on = (state == ST_STROBE) || early_q;
        ce2_on = ce_on && !part && lat_w16 &&
                 ((age < 2'(CE2_SETTLE)) || !(lat_dyn && narrow_q));
        ce1_n    = !ce_on;
        ce2_n    = !ce2_on;
        iord_n   = !(stb_on && lat_io && !lat_write);
        iowr_n   = !(stb_on && lat_io && lat_write);
        memrd_n  = !(stb_on && !lat_io && !lat_write);
        memwr_n  = !(stb_on && !lat_io && lat_write);
        card_doe = ce_on && lat_write;
        if (part)          card_addr = {lat_addr[AW-1:1], 1'b1};
        else if (lat_word) card_addr = {lat_addr[AW-1:1], 1'b0};
        else               card_addr = lat_addr;
        card_dout = part ? {lat_wdata[15:8], lat_wdata[15:8]} : lat_wdata;
        rd_data   = rd_q;
        done      = (state == ST_DONE);
        early_set = (state == ST_SETUP) && (cnt == DLY_W'(1)) && lat_odd;
        samp_en   = ce_on && ((age == 2'd0) || (state == ST_SETUP));
    end

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_split_only_dyn_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NEXT) |-> lat_dyn);

    assert_second_no_ce2_R7: assert property (@(posedge clk) disable iff (!rst_n)
        part |-> ce2_n);

endmodule

// File: rtl/pcc_io_ctrl.sv
module pcc_io_ctrl #(
    parameter int unsigned AW      = 16,
    parameter int unsigned DLY_W   = 4,
    parameter int unsigned STB_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_mode0,
    input  logic [1:0]       cfg_mode1,
    input  logic             cfg_wide0,
    input  logic             cfg_wide1,
    input  logic [DLY_W-1:0] cfg_dly0,
    input  logic [DLY_W-1:0] cfg_dly1,
    input  logic             cfg_little,
    input  logic             req_valid,
    input  logic             req_space,
    input  logic             req_word,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [15:0]      req_wdata,
    input  logic             io_narrow,
    input  logic [15:0]      card_din,
    output logic             ce1_n,
    output logic             ce2_n,
    output logic             iord_n,
    output logic             iowr_n,
    output logic             memrd_n,
    output logic             memwr_n,
    output logic [AW-1:0]    card_addr,
    output logic [15:0]      card_dout,
    output logic             card_doe,
    output logic [15:0]      rd_data,
    output logic             done
);
    logic             sel_io, sel_wide;
    logic [DLY_W-1:0] sel_dly;
    logic             early_set, samp_en, early_q, narrow_q;

    pcc_cfg_sel #(.NSP(2), .DLY_W(DLY_W)) u_cfg (
        .mode     ({cfg_mode1, cfg_mode0}),
        .wide     ({cfg_wide1, cfg_wide0}),
        .dly      ({cfg_dly1, cfg_dly0}),
        .space    (req_space),
        .sel_io   (sel_io),
        .sel_wide (sel_wide),
        .sel_dly  (sel_dly)
    );

    pcc_negsamp u_neg (
        .clk       (clk),
        .rst_n     (rst_n),
        .early_set (early_set),
        .samp_en   (samp_en),
        .io_narrow (io_narrow),
        .early_q   (early_q),
        .narrow_q  (narrow_q)
    );

    pcc_seq #(.AW(AW), .DLY_W(DLY_W), .STB_CYC(STB_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_word   (req_word),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .sel_io     (sel_io),
        .sel_wide   (sel_wide),
        .sel_little (cfg_little),
        .sel_dly    (sel_dly),
        .card_din   (card_din),
        .early_q    (early_q),
        .narrow_q   (narrow_q),
        .early_set  (early_set),
        .samp_en    (samp_en),
        .ce1_n      (ce1_n),
        .ce2_n      (ce2_n),
        .iord_n     (iord_n),
        .iowr_n     (iowr_n),
        .memrd_n    (memrd_n),
        .memwr_n    (memwr_n),
        .card_addr  (card_addr),
        .card_dout  (card_dout),
        .card_doe   (card_doe),
        .rd_data    (rd_data),
        .done       (done)
    );

    logic stb_n_all;
    assign stb_n_all = iord_n && iowr_n && memrd_n && memwr_n;

    assert_strobe_in_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_n_all |-> !ce1_n);

    assert_strobe_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb_n_all) |-> !ce1_n);

    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!iord_n, !iowr_n, !memrd_n, !memwr_n}));

    assert_ce2_with_ce1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ce2_n |-> !ce1_n);

    assert_done_idle_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ce1_n && stb_n_all));

    always_comb begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (ce1_n && ce2_n && stb_n_all && !card_doe && !done);
        end
    end

endmodule

// File: tb/sim_pcc_io_ctrl.sv
module sim_pcc_io_ctrl;
    localparam int AW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode0 = 2'b01, cfg_mode1 = 2'b00;
    logic        cfg_wide0 = 1'b1, cfg_wide1 = 1'b1;
    logic [3:0]  cfg_dly0 = '0, cfg_dly1 = '0;
    logic        cfg_little = 1'b1;
    logic        req_valid = 1'b0, req_space = 1'b0, req_word = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        io_narrow = 1'b0;
    logic [15:0] card_din;
    logic        ce1_n, ce2_n, iord_n, iowr_n, memrd_n, memwr_n, card_doe, done;
    logic [15:0] card_addr, card_dout, rd_data;

    always #4 clk = ~clk;

    function automatic logic [7:0] fpat(input logic [15:0] x);
        return (x[7:0] ^ 8'h5A) + x[15:8];
    endfunction

    assign card_din = {fpat(card_addr | 16'h0001), fpat(card_addr)};

    pcc_io_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_mode0(cfg_mode0), .cfg_mode1(cfg_mode1),
        .cfg_wide0(cfg_wide0), .cfg_wide1(cfg_wide1),
        .cfg_dly0(cfg_dly0), .cfg_dly1(cfg_dly1), .cfg_little(cfg_little),
        .req_valid(req_valid), .req_space(req_space), .req_word(req_word),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .io_narrow(io_narrow), .card_din(card_din),
        .ce1_n(ce1_n), .ce2_n(ce2_n), .iord_n(iord_n), .iowr_n(iowr_n),
        .memrd_n(memrd_n), .memwr_n(memwr_n), .card_addr(card_addr),
        .card_dout(card_dout), .card_doe(card_doe), .rd_data(rd_data), .done(done)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // half-clock monitor, samples 2 ns after every edge
    int          tick = 0, t_ce = 0, t_on = 0, t_off = 0;
    int          n_cyc = 0, n_done = 0;
    int          dly_m [2], slen_m [2], gap_m [2];
    logic [15:0] addr_m [2];
    logic [7:0]  wlo_m [2], whi_m [2];
    bit          ce2_3 [2], ce2_4 [2], ce2_hold [2];
    bit          seen_io, seen_mem, seen_wr, seen_rd, done_ce_bad;
    logic        prev_ce1 = 1'b1, prev_stb = 1'b0;

    task automatic mon_clear();
        n_cyc = 0; n_done = 0; seen_io = 0; seen_mem = 0; seen_wr = 0;
        seen_rd = 0; done_ce_bad = 0;
        for (int i = 0; i < 2; i++) begin
            dly_m[i] = -1; slen_m[i] = -1; gap_m[i] = -1; addr_m[i] = '0;
            wlo_m[i] = '0; whi_m[i] = '0; ce2_3[i] = 0; ce2_4[i] = 0; ce2_hold[i] = 0;
        end
    endtask

    always begin
        @(clk);
        #2;
        tick++;
        begin
            logic stb;
            int   cur, rel;
            stb = !iord_n || !iowr_n || !memrd_n || !memwr_n;
            if (prev_ce1 && !ce1_n) begin
                if (n_cyc < 2) addr_m[n_cyc] = card_addr;
                n_cyc++;
                t_ce = tick;
            end
            cur = (n_cyc >= 2) ? 1 : ((n_cyc > 0) ? n_cyc - 1 : 0);
            rel = tick - t_ce;
            if (!ce1_n) begin
                if (!prev_stb && stb) begin dly_m[cur] = rel; t_on = tick; end
                if (stb) begin wlo_m[cur] = card_dout[7:0]; whi_m[cur] = card_dout[15:8]; end
                if (rel == 3) ce2_3[cur] = !ce2_n;
                if (rel == 4) ce2_4[cur] = !ce2_n;
                ce2_hold[cur] = !ce2_n;
            end
            if (prev_stb && !stb) begin slen_m[cur] = tick - t_on; t_off = tick; end
            if (!prev_ce1 && ce1_n) gap_m[cur] = tick - t_off;
            if (!iord_n || !iowr_n) seen_io = 1;
            if (!memrd_n || !memwr_n) seen_mem = 1;
            if (!iowr_n || !memwr_n) seen_wr = 1;
            if (!iord_n || !memrd_n) seen_rd = 1;
            if (done) begin n_done++; if (!ce1_n) done_ce_bad = 1; end
            prev_ce1 = ce1_n;
            prev_stb = stb;
        end
    end

    task automatic do_access(input bit sp, input bit word, input bit wr,
                             input logic [15:0] a, input logic [15:0] wd,
                             input bit nar, input bit glitch);
        bit          io    = ((sp ? cfg_mode1 : cfg_mode0) == 2'b01);
        bit          wide  = sp ? cfg_wide1 : cfg_wide0;
        int          d     = int'(sp ? cfg_dly1 : cfg_dly0);
        bit          w16   = word && wide;
        bit          split = io && wide && cfg_little && word && nar;
        int          ncy   = split ? 2 : 1;
        logic [15:0] a0    = word ? {a[15:1], 1'b0} : a;
        logic [15:0] erd   = w16 ? {fpat(a0 | 16'h0001), fpat(a0)} : {8'h00, fpat(a0)};
        string       tg;
        int          w = 0;
        logic [15:0] rd;
        if (split)           tg = "R6";
        else if (!w16)       tg = "R9";
        else if (nar)        tg = "R8";
        else                 tg = "R5";
        @(posedge clk); #1;
        io_narrow = nar;
        mon_clear();
        req_space = sp; req_word = word; req_write = wr; req_addr = a; req_wdata = wd;
        req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (glitch) begin
            @(posedge clk); #1;
            req_addr = ~a; req_word = ~word; req_valid = 1'b1;
            @(posedge clk); #1;
            req_valid = 1'b0;
        end
        while (!done && w < 200) begin @(posedge clk); #2; w++; end
        chk(w < 200, "R10", "done timeout", w, 0);
        rd = rd_data;
        repeat (5) @(posedge clk);
        #2;
        chk(n_cyc == ncy, tg, "cycle count", n_cyc, ncy);
        for (int c = 0; c < 2; c++) begin
            if (c < ncy && c < n_cyc) begin
                chk(dly_m[c] == d, "R3", "strobe delay half-clocks", dly_m[c], d);
                chk(slen_m[c] == (d % 2) + 4, "R4", "strobe length half-clocks", slen_m[c], (d % 2) + 4);
                chk(gap_m[c] == 2, "R4", "strobe-to-enable release", gap_m[c], 2);
                chk(addr_m[c] == (c == 1 ? (a | 16'h0001) : a0), tg, "cycle address",
                    int'(addr_m[c]), int'(c == 1 ? (a | 16'h0001) : a0));
            end
        end
        chk(ce2_3[0] == w16, "R7", "ce2 early in cycle", ce2_3[0], w16);
        chk(ce2_4[0] == (w16 && !split), "R7", "ce2 after settle", ce2_4[0], w16 && !split);
        chk(ce2_hold[0] == (w16 && !split), "R7", "ce2 at hold", ce2_hold[0], w16 && !split);
        if (split) chk(!ce2_3[1] && !ce2_hold[1], "R7", "ce2 in second byte cycle", ce2_hold[1], 0);
        if (!wr) begin
            chk(rd == erd, tg, "read data", rd, erd);
        end else begin
            chk(wlo_m[0] == wd[7:0], tg, "low lane write data", wlo_m[0], wd[7:0]);
            if (split) chk(wlo_m[1] == wd[15:8], "R6", "second byte write data", wlo_m[1], wd[15:8]);
            if (w16 && !split) chk(whi_m[0] == wd[15:8], "R5", "high lane write data", whi_m[0], wd[15:8]);
        end
        chk(seen_io == io && seen_mem == !io, "R2", "strobe family io", seen_io, io);
        chk(seen_wr == wr && seen_rd == !wr, "R2", "strobe direction wr", seen_wr, wr);
        chk(n_done == 2 && !done_ce_bad, "R10", "done half-clock samples", n_done, 2);
        if (glitch) chk(n_cyc == ncy && n_done == 2, "R11", "busy request ignored", n_cyc, ncy);
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        mon_clear();
        repeat (3) @(posedge clk);
        #2;
        chk(ce1_n && ce2_n && iord_n && iowr_n && memrd_n && memwr_n && !card_doe && !done,
            "R1", "outputs quiet in reset", {ce1_n, ce2_n, iord_n, iowr_n, card_doe, done}, 6'b111100);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R3/R4: every delay value on a split read and a plain word write
        for (int dv = 0; dv < 16; dv++) begin
            cfg_dly0 = 4'(dv);
            do_access(1'b0, 1'b1, 1'b0, 16'h1234 + 16'(dv * 6), 16'h0, 1'b1, 1'b0);
            do_access(1'b0, 1'b1, 1'b1, 16'h0400 + 16'(dv * 2), 16'hA000 + 16'(dv), 1'b0, 1'b0);
        end
        // R6 split write
        cfg_dly0 = 4'd3;
        do_access(1'b0, 1'b1, 1'b1, 16'h2222, 16'hBEEF, 1'b1, 1'b0);
        // R8 big endian ignores narrow
        cfg_little = 1'b0;
        do_access(1'b0, 1'b1, 1'b0, 16'h3330, 16'h0, 1'b1, 1'b0);
        do_access(1'b0, 1'b1, 1'b1, 16'h3332, 16'hCAFE, 1'b1, 1'b0);
        cfg_little = 1'b1;
        // R8/R2 memory mode ignores narrow
        cfg_dly1 = 4'd2;
        do_access(1'b1, 1'b1, 1'b0, 16'h4440, 16'h0, 1'b1, 1'b0);
        do_access(1'b1, 1'b1, 1'b1, 16'h4442, 16'h1357, 1'b1, 1'b0);
        // R9 byte at odd address, word to 8-bit space
        do_access(1'b0, 1'b0, 1'b0, 16'h5555, 16'h0, 1'b1, 1'b0);
        cfg_wide0 = 1'b0;
        do_access(1'b0, 1'b1, 1'b0, 16'h6667, 16'h0, 1'b1, 1'b0);
        do_access(1'b0, 1'b1, 1'b1, 16'h6668, 16'h9A7C, 1'b0, 1'b0);
        cfg_wide0 = 1'b1;
        // R11 request pulsed while busy
        cfg_dly0 = 4'd0;
        do_access(1'b0, 1'b1, 1'b0, 16'h7770, 16'h0, 1'b0, 1'b1);
        do_access(1'b0, 1'b1, 1'b1, 16'h7772, 16'h2468, 1'b1, 1'b1);

        // constrained random mix
        for (int n = 0; n < 150; n++) begin
            logic [31:0] r = $urandom;
            cfg_mode0  = (r[0]) ? 2'b01 : 2'(r[2:1]);
            cfg_mode1  = (r[3]) ? 2'b01 : 2'(r[5:4]);
            cfg_wide0  = r[6] | r[7];
            cfg_wide1  = r[8];
            cfg_dly0   = r[12:9];
            cfg_dly1   = r[16:13];
            cfg_little = r[17] | r[18];
            do_access(r[19], r[20] | r[21], r[22], 16'($urandom), 16'($urandom),
                      r[23], r[24] & r[25]);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule